// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block holds the configuration bytes that steer the legacy memory area below 1 MiB in a host bridge, and decides for each memory request whether it is served by DRAM or forwarded to the PCI/legacy bus. Configuration software writes the bytes through a dword-wide port with four byte enables and reads them back through the same dword address. Seven attribute bytes give each shadow segment separate read and write steering. A control byte opens, closes and locks the system-management RAM window. A read-only byte reports installed memory size.

The router is combinational on the request (address, read/write, system-management flag) and on the registered configuration. A configuration write therefore changes routing as one step on the clock edge that ends the write cycle. Addresses outside the legacy area are routed by a top-of-memory parameter.

Top module: `legacy_window_decoder`

## Requirements
- R1: After reset every attribute byte (offsets 0x59 to 0x5F) reads 0x00, the SMRAM control byte (offset 0x72) reads 0x02, and every legacy segment and the SMRAM window route to PCI (mem_to_dram = 0).
- R2: The byte at offset 0x57 (dword 0x15, lane 3) reads min(RAM_MB / 8, 255), and writes to it have no effect.
- R3: A write updates exactly those attribute bytes whose lane enable (cfg_be bit n = byte address 4*cfg_addr+n) is set. Bytes without an enable, and offsets that hold no register, are unchanged and read 0 when unimplemented.
- R4: A configuration write changes routing and read data only from the clock edge that ends the write cycle. Without a write the configuration holds.
- R5: The BIOS segment 0xF0000 to 0xFFFFF takes its field from bits 5:4 of byte 0x59. Field bit 0 set sends reads to DRAM and field bit 1 set sends writes to DRAM; a clear bit sends that access type to PCI.
- R6: Expansion segment k (k = 0..11, 16 KiB at 0xC0000 + k*0x4000) takes its field from byte 0x5A + k/2: bits 1:0 for even k and bits 5:4 for odd k, with the same read/write meaning as R5.
- R7: A non-SMM access to 0xA0000 to 0xBFFFF goes to DRAM when open bit 6 of the SMRAM byte is set, and to PCI when it is clear.
- R8: An SMM access to 0xA0000 to 0xBFFFF goes to DRAM when global enable bit 3 or open bit 6 is set, and to PCI otherwise.
- R9: Lock bit 4 of the SMRAM byte, once written as 1, stays set until reset. While it is set, or in the same write that sets it, open bit 6 is stored as 0 whatever is written.
- R10: Addresses below 0xA0000 or at or above 0x100000 go to DRAM when below TOP_OF_MEM and to PCI at or above it.
- R11: Bits 2:0 of the SMRAM byte always read 3'b010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_addr | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte lane enables for the write |
| cfg_wdata | input | 32 | Write data, lane n in bits 8n+7:8n |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| mem_addr | input | ADDR_W | Memory request address |
| mem_write | input | 1 | 1 for a write request, 0 for a read |
| mem_smm | input | 1 | Requester is in system-management mode |
| mem_to_dram | output | 1 | 1 routes the request to DRAM, 0 to PCI/legacy bus |

## Verification
The assertions assume that every input is at a known level from reset onward, that TOP_OF_MEM lies above 1 MiB, and that a configuration write lasts exactly one cycle. The bench drives every input from time zero, changes inputs only on the falling edge, and issues each write as a one-cycle strobe. Routing is sampled just after inputs settle, so the combinational router is observed against registered configuration that is stable.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

    localparam int          NUM_ATTR      = 7;
    localparam int          NUM_EXP_SEG   = 12;
    localparam int          EXP_SEG_SHIFT = 14;

    localparam logic [7:0]  ATTR_OFS      = 8'h59;
    localparam logic [7:0]  SMRAM_OFS     = 8'h72;
    localparam logic [7:0]  RAMSZ_OFS     = 8'h57;

    localparam int          SM_OPEN_BIT   = 6;
    localparam int          SM_LOCK_BIT   = 4;
    localparam int          SM_GEN_BIT    = 3;
    localparam logic [2:0]  SM_FIXED_LOW  = 3'b010;
    localparam logic [7:0]  SMRAM_RST     = 8'h02;

    localparam logic [31:0] SMRAM_BASE    = 32'h000A_0000;
    localparam logic [31:0] EXP_BASE      = 32'h000C_0000;
    localparam logic [31:0] BIOS_BASE     = 32'h000F_0000;
    localparam logic [31:0] LEGACY_END    = 32'h0010_0000;

    typedef struct packed {
        logic [NUM_ATTR-1:0][7:0] attr;
        logic [7:0]               smram;
    } cfg_state_t;

    typedef struct packed {
        logic [1:0]                  bios;
        logic [NUM_EXP_SEG-1:0][1:0] exp;
        logic                        d_open;
        logic                        g_smrame;
    } route_cfg_t;

endpackage

// File: rtl/lwd_cfg_regs.sv
module lwd_cfg_regs
    import lwd_pkg::*;
#(
    parameter int RAM_MB = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  dw_addr,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output route_cfg_t  rcfg
);

    localparam int         RAM_UNITS = RAM_MB / 8;
    localparam logic [7:0] RAM_BYTE  = (RAM_UNITS > 255) ? 8'hFF : 8'(RAM_UNITS);

    cfg_state_t st_d, st_q;

    function automatic logic [7:0] lane_addr(input logic [5:0] dw, input int lane);
        return {dw, 2'(lane)};
    endfunction

    function automatic logic [7:0] smram_merge(input logic [7:0] cur, input logic [7:0] wr);
        logic lock;
        lock = cur[SM_LOCK_BIT] | wr[SM_LOCK_BIT];
        return {wr[7], wr[SM_OPEN_BIT] & ~lock, wr[5], lock, wr[SM_GEN_BIT], SM_FIXED_LOW};
    endfunction

    // next-state: byte-lane writes into the attribute and SMRAM bytes
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int b = 0; b < 4; b++) begin
                if (be[b]) begin
                    for (int a = 0; a < NUM_ATTR; a++) begin
                        if (lane_addr(dw_addr, b) == ATTR_OFS + 8'(a)) begin
                            st_d.attr[a] = wdata[8*b +: 8];
                        end
                    end
                    if (lane_addr(dw_addr, b) == SMRAM_OFS) begin
                        st_d.smram = smram_merge(st_q.smram, wdata[8*b +: 8]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.attr  <= '0;
            st_q.smram <= SMRAM_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux over the four lanes of the addressed dword
    always_comb begin
        rdata = '0;
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < NUM_ATTR; a++) begin
                if (lane_addr(dw_addr, b) == ATTR_OFS + 8'(a)) begin
                    rdata[8*b +: 8] = st_q.attr[a];
                end
            end
            if (lane_addr(dw_addr, b) == SMRAM_OFS) begin
                rdata[8*b +: 8] = st_q.smram;
            end
            if (lane_addr(dw_addr, b) == RAMSZ_OFS) begin
                rdata[8*b +: 8] = RAM_BYTE;
            end
        end
    end

    // per-segment routing fields for the router
    always_comb begin
        rcfg.bios     = st_q.attr[0][5:4];
        rcfg.d_open   = st_q.smram[SM_OPEN_BIT];
        rcfg.g_smrame = st_q.smram[SM_GEN_BIT];
        for (int k = 0; k < NUM_EXP_SEG; k++) begin
            rcfg.exp[k] = st_q.attr[1 + k/2][(k % 2)*4 +: 2];
        end
    end

endmodule

// File: rtl/lwd_router.sv
module lwd_router
    import lwd_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] TOP_OF_MEM = ADDR_W'(32'h8000_0000)
) (
    input  route_cfg_t        rcfg,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_write,
    input  logic              mem_smm,
    output logic              to_dram
);

    localparam logic [ADDR_W-1:0] SEG_SIZE = ADDR_W'(1) << EXP_SEG_SHIFT;

    logic [NUM_EXP_SEG-1:0] seg_hit;
    logic [NUM_EXP_SEG-1:0] seg_go;

    for (genvar k = 0; k < NUM_EXP_SEG; k++) begin : g_seg
        localparam logic [ADDR_W-1:0] SEG_LO = ADDR_W'(EXP_BASE) + ADDR_W'(k) * SEG_SIZE;
        assign seg_hit[k] = (mem_addr >= SEG_LO) && (mem_addr < SEG_LO + SEG_SIZE);
        assign seg_go[k]  = mem_write ? rcfg.exp[k][1] : rcfg.exp[k][0];
    end

    logic in_smram, in_exp, in_bios;

    always_comb begin
        in_smram = (mem_addr >= ADDR_W'(SMRAM_BASE)) && (mem_addr < ADDR_W'(EXP_BASE));
        in_exp   = (mem_addr >= ADDR_W'(EXP_BASE))   && (mem_addr < ADDR_W'(BIOS_BASE));
        in_bios  = (mem_addr >= ADDR_W'(BIOS_BASE))  && (mem_addr < ADDR_W'(LEGACY_END));
        if (in_smram) begin
            to_dram = mem_smm ? (rcfg.g_smrame | rcfg.d_open) : rcfg.d_open;
        end else if (in_exp) begin
            to_dram = |(seg_hit & seg_go);
        end else if (in_bios) begin
            to_dram = mem_write ? rcfg.bios[1] : rcfg.bios[0];
        end else begin
            to_dram = mem_addr < TOP_OF_MEM;
        end
    end

endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
    import lwd_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                RAM_MB     = 4096,
    parameter logic [ADDR_W-1:0] TOP_OF_MEM = ADDR_W'(32'h8000_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [5:0]        cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_write,
    input  logic              mem_smm,
    output logic              mem_to_dram
);

    route_cfg_t rcfg;

    lwd_cfg_regs #(
        .RAM_MB (RAM_MB)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .dw_addr (cfg_addr),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .rcfg    (rcfg)
    );

    lwd_router #(
        .ADDR_W     (ADDR_W),
        .TOP_OF_MEM (TOP_OF_MEM)
    ) u_router (
        .rcfg      (rcfg),
        .mem_addr  (mem_addr),
        .mem_write (mem_write),
        .mem_smm   (mem_smm),
        .to_dram   (mem_to_dram)
    );

endmodule

// File: rtl/lwd_checker.sv
module lwd_checker
    import lwd_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                RAM_MB     = 4096,
    parameter logic [ADDR_W-1:0] TOP_OF_MEM = ADDR_W'(32'h8000_0000)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [5:0]        cfg_addr,
    input logic [3:0]        cfg_be,
    input logic [31:0]       cfg_wdata,
    input logic [31:0]       cfg_rdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_smm,
    input logic              mem_to_dram,
    input route_cfg_t        rcfg
);

    localparam int         UNITS    = RAM_MB / 8;
    localparam logic [7:0] RAM_BYTE = (UNITS > 255) ? 8'hFF : 8'(UNITS);

    logic in_smram;
    assign in_smram = (mem_addr >= ADDR_W'(SMRAM_BASE)) && (mem_addr < ADDR_W'(EXP_BASE));

    // R4: configuration holds while no write is presented
    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> $stable(rcfg));

    // R7: closed window hides DRAM from non-SMM requesters
    a_r7_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
        (in_smram && !mem_smm && !rcfg.d_open) |-> !mem_to_dram);

    // R8: global enable gives SMM requesters DRAM
    a_r8_smm_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (in_smram && mem_smm && rcfg.g_smrame) |-> mem_to_dram);

    // R9: a write carrying the lock bit leaves the window closed
    a_r9_lock_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_addr == 6'h1C && cfg_be[2] && cfg_wdata[16 + SM_LOCK_BIT])
        |=> !rcfg.d_open);

    // R10: above top of memory goes to PCI, low memory goes to DRAM
    a_r10_above_tom: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr >= TOP_OF_MEM) |-> !mem_to_dram);
    a_r10_low_dram: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr < ADDR_W'(SMRAM_BASE)) |-> mem_to_dram);

    // R11: fixed low bits of the SMRAM byte
    a_r11_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'h1C) |-> (cfg_rdata[18:16] == SM_FIXED_LOW));

    // R2: memory size byte is constant
    a_r2_ram_size: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 6'h15) |-> (cfg_rdata[31:24] == RAM_BYTE));

endmodule

bind legacy_window_decoder lwd_checker #(
    .ADDR_W     (ADDR_W),
    .RAM_MB     (RAM_MB),
    .TOP_OF_MEM (TOP_OF_MEM)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_addr    (cfg_addr),
    .cfg_be      (cfg_be),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .mem_addr    (mem_addr),
    .mem_smm     (mem_smm),
    .mem_to_dram (mem_to_dram),
    .rcfg        (rcfg)
);

// File: tb/sim_legacy_window_decoder.sv
`timescale 1ns/1ps
module sim_legacy_window_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] mem_addr = '0;
    logic        mem_write = 1'b0;
    logic        mem_smm = 1'b0;
    logic        mem_to_dram;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] attr_m [7];

    always #10 clk = ~clk;

    legacy_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .mem_write(mem_write), .mem_smm(mem_smm),
        .mem_to_dram(mem_to_dram)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0;
        for (int b = 0; b < 4; b++) begin
            int ofs = int'(a) * 4 + b;
            if (be[b] && ofs >= 'h59 && ofs <= 'h5F) attr_m[ofs - 'h59] = d[8*b +: 8];
        end
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic route(input logic [31:0] a, input logic w, input logic s, output logic r);
        mem_addr = a; mem_write = w; mem_smm = s;
        #1;
        r = mem_to_dram;
    endtask

    function automatic logic [1:0] exp_field(input int k);
        logic [7:0] byt = attr_m[1 + k/2];
        return (k % 2 == 1) ? byt[5:4] : byt[1:0];
    endfunction

    task automatic t_reset;
        logic [31:0] d; logic r;
        cfg_read(6'h16, d); chk("R1 attr 58..5B", d, 32'h0);
        cfg_read(6'h17, d); chk("R1 attr 5C..5F", d, 32'h0);
        cfg_read(6'h1C, d); chk("R1/R11 smram", d, 32'h0002_0000);
        cfg_read(6'h15, d); chk("R2 ram size", d, 32'hFF00_0000);
        route(32'hA0000, 0, 0, r); chk("R1 smram pci", r, 0);
        route(32'hA0000, 0, 1, r); chk("R1 smram smm pci", r, 0);
        route(32'hC0000, 0, 0, r); chk("R1 exp pci", r, 0);
        route(32'hF0000, 1, 0, r); chk("R1 bios pci", r, 0);
    endtask

    task automatic t_lanes;
        logic [31:0] d; logic r;
        cfg_write(6'h16, 4'b1010, 32'h3322_1100);
        cfg_read(6'h16, d); chk("R3 partial lanes", d, 32'h3300_1100);
        route(32'hF8000, 0, 0, r); chk("R5 bios read", r, 1);
        route(32'hF8000, 1, 0, r); chk("R5 bios write", r, 0);
        route(32'hC8000, 1, 0, r); chk("R6 seg2 write", r, 1);
        route(32'hCFFFF, 0, 0, r); chk("R6 seg3 read", r, 1);
        route(32'hC0000, 0, 0, r); chk("R6 seg0 untouched", r, 0);
    endtask

    task automatic t_timing;
        logic r;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 6'h17; cfg_be = 4'b0001; cfg_wdata = 32'h0000_0002;
        mem_addr = 32'hD0000; mem_write = 1'b1; mem_smm = 1'b0;
        #2; r = mem_to_dram; chk("R4 before edge", r, 0);
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_be = '0; attr_m[3] = 8'h02;
        #1; r = mem_to_dram; chk("R4 after edge", r, 1);
        repeat (3) @(negedge clk);
        #1; r = mem_to_dram; chk("R4 holds", r, 1);
    endtask

    task automatic t_all_segments;
        logic r;
        cfg_write(6'h16, 4'b1100, 32'h1221_0000);
        cfg_write(6'h17, 4'b1111, 32'h2001_2112);
        for (int k = 0; k < 12; k++) begin
            logic [31:0] lo = 32'hC0000 + 32'(k) * 32'h4000;
            logic [1:0]  f  = exp_field(k);
            route(lo, 0, 0, r);           chk($sformatf("R6 seg%0d rd lo", k), r, f[0]);
            route(lo + 32'h3FFF, 1, 0, r); chk($sformatf("R6 seg%0d wr hi", k), r, f[1]);
        end
    endtask

    task automatic t_ramsize;
        logic [31:0] d;
        cfg_write(6'h15, 4'b1000, 32'h1200_0000);
        cfg_read(6'h15, d); chk("R2 write ignored", d, 32'hFF00_0000);
        cfg_write(6'h14, 4'b1111, 32'hFFFF_FFFF);
        cfg_read(6'h14, d); chk("R3 unimplemented", d, 32'h0);
    endtask

    task automatic t_smram;
        logic [31:0] d; logic r;
        cfg_write(6'h1C, 4'b0100, 32'h0048_0000);
        cfg_read(6'h1C, d); chk("R11 smram 48", d, 32'h004A_0000);
        route(32'hA0000, 0, 0, r); chk("R7 open nonsmm", r, 1);
        route(32'hBFFFF, 1, 1, r); chk("R8 open smm", r, 1);
        route(32'hC0000, 0, 0, r); chk("R7 window end", r, exp_field(0)[0]);
        cfg_write(6'h1C, 4'b0100, 32'h0008_0000);
        route(32'hA0000, 0, 0, r); chk("R7 closed nonsmm", r, 0);
        route(32'hA0000, 0, 1, r); chk("R8 gen smm", r, 1);
        cfg_write(6'h1C, 4'b0100, 32'h0000_0000);
        route(32'hB0000, 1, 1, r); chk("R8 off smm", r, 0);
        cfg_write(6'h1C, 4'b0100, 32'h0040_0000);
        route(32'hB0000, 0, 1, r); chk("R8 open only smm", r, 1);
    endtask

    task automatic t_outside;
        logic r;
        route(32'h0009FFFF, 0, 0, r); chk("R10 below window", r, 1);
        route(32'h00100000, 1, 0, r); chk("R10 1MiB", r, 1);
        route(32'h7FFFFFFF, 0, 0, r); chk("R10 below tom", r, 1);
        route(32'h80000000, 0, 0, r); chk("R10 at tom", r, 0);
    endtask

    task automatic t_lock;
        logic [31:0] d; logic r;
        cfg_write(6'h1C, 4'b0100, 32'h0050_0000);
        cfg_read(6'h1C, d); chk("R9 lock same write", d, 32'h0012_0000);
        cfg_write(6'h1C, 4'b0100, 32'h0048_0000);
        cfg_read(6'h1C, d); chk("R9 open blocked", d, 32'h001A_0000);
        route(32'hBFFFF, 0, 0, r); chk("R9 nonsmm closed", r, 0);
        route(32'hBFFFF, 0, 1, r); chk("R9 smm dram", r, 1);
        cfg_write(6'h1C, 4'b0100, 32'h0000_0000);
        cfg_read(6'h1C, d); chk("R9 lock sticky", d, 32'h0012_0000);
    endtask

    initial begin
        for (int i = 0; i < 7; i++) attr_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lanes();
        t_timing();
        t_all_segments();
        t_ramsize();
        t_smram();
        t_outside();
        t_lock();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule